// File: doc/BRIEF.md
# Power Mode and PHY Reset Control Register

This block is a memory-mapped control register for a network controller. Software uses it to put the controller into one of two low-power modes and to start a PHY reset that times itself. It sits on a simple register bus with an address, a write strobe, a read strobe and 32-bit data buses. The read data path is combinational and is qualified by the read strobe. The outputs give the active power mode, the PHY reset line, a ready flag, and one enable each for wake-frame detection and energy detection.

A sleep state machine has three states. `ST_RUN` is normal operation with ready high. `ST_SLEEP` is a reduced-power mode with ready low. `ST_SETTLE` is the recovery interval after a wake. Its transitions are as follows. *enter_sleep* (`ST_RUN` to `ST_SLEEP`) fires on an accepted control write that selects mode 01 or 10. *wake* (`ST_SLEEP` to `ST_SETTLE`) fires on any write to the wake address. *settled* (`ST_SETTLE` to `ST_RUN`) fires when the settle counter expires.

A second machine times the PHY reset. It has the states `PHY_IDLE` and `PHY_HOLD`. *arm* (`PHY_IDLE` to `PHY_HOLD`) fires on an accepted write with bit 10 set. *expire* (`PHY_HOLD` to `PHY_IDLE`) fires after the hold count. An access gate accepts control writes only after a read has unlocked it. Every reset and every wake locks the gate again.

Top module: `pwr_mgmt_ctl`

## Requirements
- R1: An accepted control write with mode field bits 13:12 equal to 01 drives `pwr_mode`=01 and `wake_frame_en`=1 from the next cycle. A value of 10 drives `pwr_mode`=10 and `energy_det_en`=1. A value of 00 keeps normal mode, with both enables low.
- R2: A control write with mode field 11 leaves `pwr_mode` unchanged and keeps ready high. The other fields of that same write still act.
- R3: Entering mode 01 or 10 clears `ready` on the next cycle. In a low-power mode, a write of any data to `WAKE_ADDR` sets `pwr_mode` to 00 on the next cycle. `ready` then stays 0 for `SETTLE_CYC` cycles after that write edge and reads 1 afterwards.
- R4: While `ready` is 0, writes to any address other than `WAKE_ADDR` have no effect on the mode or on the PHY reset.
- R5: A read with `rd_en`=1 at `CTRL_ADDR` returns `pwr_mode` in bits 13:12, `phy_rst` in bit 10 and `ready` in bit 0, with every other bit 0. `rdata` is 0 for any other access. This holds in every power mode.
- R6: After reset, and after each wake, control writes have no effect until at least one cycle with `rd_en`=1 (at any address) has occurred. The wake write itself needs no prior read.
- R7: An accepted write with bit 10 set raises `phy_rst` from the next cycle. `phy_rst` stays high for exactly ceil(`CLK_HZ`*`HOLD_US`/1e6) cycles (12500 at the defaults) and then clears by itself.
- R8: While `phy_rst` is 1, writes to bit 10 with either value neither restart nor shorten the hold.
- R9: After reset, `pwr_mode`=00, `phy_rst`=0, `ready`=1, both enables are 0, and writes are locked.
- R10: A write to `WAKE_ADDR` while not in a low-power mode changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| pwr_mode | output | 2 | Active power mode |
| phy_rst | output | 1 | PHY reset, active high |
| ready | output | 1 | Block ready for register writes |
| wake_frame_en | output | 1 | Wake-frame and magic-packet detection enable |
| energy_det_en | output | 1 | Energy detection enable |

## Verification
A sleep machine in the wrong state shows up on `ready` and `pwr_mode` at the very next clock. A gate that unlocks too early or too late changes the effect of the first write after a reset or a wake, so the fault is seen one cycle after that write. A hold or settle counter that is off by one moves the falling edge of `phy_rst`, or the rising edge of `ready`, by one cycle. The reference model compares every output on every clock, so such a shift is reported in the exact cycle where it occurs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL    = 2'b00,
        PM_WAKEFRAME = 2'b01,
        PM_ENERGY    = 2'b10,
        PM_RSVD      = 2'b11
    } pm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SETTLE = 2'd2
    } pwr_st_e;

    typedef enum logic {
        PHY_IDLE = 1'b0,
        PHY_HOLD = 1'b1
    } phy_st_e;

    localparam int MODE_LSB  = 12;
    localparam int MODE_MSB  = 13;
    localparam int PHY_BIT   = 10;
    localparam int READY_BIT = 0;

endpackage

// File: rtl/pmc_access.sv
module pmc_access #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h84,
    parameter logic [ADDR_W-1:0] WAKE_ADDR = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              ready,
    input  logic              wake_evt,
    output logic              ctrl_wr,
    output logic              wake_req
);

    logic unlocked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
        end else if (wake_evt) begin
            unlocked_q <= 1'b0;
        end else if (rd_en) begin
            unlocked_q <= 1'b1;
        end
    end

    always_comb begin
        ctrl_wr  = wr_en && (addr == CTRL_ADDR) && unlocked_q && ready;
        wake_req = wr_en && (addr == WAKE_ADDR);
    end

    // R6
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !unlocked_q);

    // R6
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wake_evt) |=> unlocked_q);

endmodule

// File: rtl/pmc_power_fsm.sv
module pmc_power_fsm
    import pmc_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] wr_mode,
    input  logic       wake_req,
    output logic [1:0] mode_o,
    output logic       ready_o,
    output logic       wake_evt_o
);

    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    pwr_st_e          state_q, state_d;
    pm_mode_e         mode_q;
    logic [SET_W-1:0] settle_q;
    logic             sleep_sel;

    assign sleep_sel = (wr_mode == PM_WAKEFRAME) || (wr_mode == PM_ENERGY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (ctrl_wr && sleep_sel)   state_d = ST_SLEEP;
            ST_SLEEP:  if (wake_req)               state_d = ST_SETTLE;
            ST_SETTLE: if (settle_q == SET_LAST)   state_d = ST_RUN;
            default:                               state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= PM_NORMAL;
            settle_q <= '0;
        end else begin
            if (state_q == ST_SLEEP && wake_req) begin
                mode_q <= PM_NORMAL;
            end else if (ctrl_wr && wr_mode != PM_RSVD) begin
                mode_q <= pm_mode_e'(wr_mode);
            end
            if (state_q == ST_SETTLE) begin
                settle_q <= settle_q + SET_W'(1);
            end else begin
                settle_q <= '0;
            end
        end
    end

    always_comb begin
        mode_o     = mode_q;
        ready_o    = (state_q == ST_RUN);
        wake_evt_o = (state_q == ST_SLEEP) && wake_req;
    end

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != PM_RSVD);

    // R3
    wake_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && wake_req) |=> (mode_q == PM_NORMAL && state_q == ST_SETTLE));

    // R3
    settle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(settle_q) == SET_LAST));

endmodule

// File: rtl/pmc_phy_timer.sv
module pmc_phy_timer
    import pmc_pkg::*;
#(
    parameter int HOLD_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic phy_rst
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    phy_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             arm;

    assign arm = wr_stb && wr_bit;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PHY_IDLE: if (arm)               st_d = PHY_HOLD;
            PHY_HOLD: if (cnt_q == CNT_LAST) st_d = PHY_IDLE;
            default:                         st_d = PHY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PHY_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == PHY_HOLD) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        phy_rst = (st_q == PHY_HOLD);
    end

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PHY_HOLD && cnt_q != CNT_LAST) |=> (st_q == PHY_HOLD && cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R7
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> ($past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/pwr_mgmt_ctl.sv
module pwr_mgmt_ctl
    import pmc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h84,
    parameter logic [ADDR_W-1:0] WAKE_ADDR = 8'h64,
    parameter int CLK_HZ     = 125_000_000,
    parameter int HOLD_US    = 100,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [1:0]        pwr_mode,
    output logic              phy_rst,
    output logic              ready,
    output logic              wake_frame_en,
    output logic              energy_det_en
);

    localparam longint unsigned HOLD_PROD = longint'(CLK_HZ) * longint'(HOLD_US);
    localparam int HOLD_CYC = int'((HOLD_PROD + 64'd999_999) / 64'd1_000_000);

    logic       ctrl_wr;
    logic       wake_req;
    logic       wake_evt;
    logic [1:0] mode_w;
    logic       ready_w;
    logic       phy_w;
    logic       unused_wdata;

    assign unused_wdata = &{1'b0, wdata[31:MODE_MSB+1], wdata[11], wdata[PHY_BIT-1:0]};

    pmc_access #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .WAKE_ADDR (WAKE_ADDR)
    ) u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .ready    (ready_w),
        .wake_evt (wake_evt),
        .ctrl_wr  (ctrl_wr),
        .wake_req (wake_req)
    );

    pmc_power_fsm #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_mode    (wdata[MODE_MSB:MODE_LSB]),
        .wake_req   (wake_req),
        .mode_o     (mode_w),
        .ready_o    (ready_w),
        .wake_evt_o (wake_evt)
    );

    pmc_phy_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (ctrl_wr),
        .wr_bit  (wdata[PHY_BIT]),
        .phy_rst (phy_w)
    );

    always_comb begin
        rdata = '0;
        if (rd_en && addr == CTRL_ADDR) begin
            rdata[MODE_MSB:MODE_LSB] = mode_w;
            rdata[PHY_BIT]           = phy_w;
            rdata[READY_BIT]         = ready_w;
        end
        pwr_mode      = mode_w;
        phy_rst       = phy_w;
        ready         = ready_w;
        wake_frame_en = (mode_w == PM_WAKEFRAME);
        energy_det_en = (mode_w == PM_ENERGY);
    end

    // R4
    gated_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !(wr_en && addr == WAKE_ADDR)) |=> $stable(pwr_mode));

    // R4
    gated_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !phy_rst) |=> !phy_rst);

endmodule

// File: tb/pwr_mgmt_ctl_test.sv
`timescale 1ns/1ps
module pwr_mgmt_ctl_test;

    localparam logic [7:0] CTRL = 8'h84;
    localparam logic [7:0] WAKE = 8'h64;
    localparam logic [7:0] OTHR = 8'h20;
    localparam int HOLD   = 12500;
    localparam int SETTLE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwr_mode;
    logic        phy_rst, ready, wake_frame_en, energy_det_en;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode = 0;
    int m_phy_left = 0;
    int m_settle = 0;
    bit m_sleep = 1'b0;
    bit m_unl = 1'b0;

    always #4 clk = ~clk;

    pwr_mgmt_ctl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pwr_mode(pwr_mode), .phy_rst(phy_rst),
        .ready(ready), .wake_frame_en(wake_frame_en), .energy_det_en(energy_det_en)
    );

    function automatic bit m_ready();
        return !m_sleep && (m_settle == 0);
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            bit wake, ok;
            wake = wr_en && addr == WAKE && m_sleep;
            ok   = wr_en && addr == CTRL && m_unl && m_ready();
            if (m_phy_left > 0) m_phy_left--;
            else if (ok && wdata[10]) m_phy_left = HOLD;
            if (m_settle > 0) m_settle--;
            if (wake) begin
                m_mode = 0; m_sleep = 1'b0; m_settle = SETTLE; m_unl = 1'b0;
            end else if (ok && wdata[13:12] != 2'b11) begin
                m_mode = int'(wdata[13:12]);
                if (m_mode != 0) m_sleep = 1'b1;
            end
            if (rd_en && !wake) m_unl = 1'b1;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [31:0] er;
            er = '0;
            if (rd_en && addr == CTRL) begin
                er[13:12] = 2'(m_mode);
                er[10] = (m_phy_left > 0);
                er[0] = m_ready();
            end
            check("R1", "pwr_mode", {30'b0, pwr_mode}, 32'(m_mode));
            check("R1", "wake_frame_en", {31'b0, wake_frame_en}, {31'b0, m_mode == 1});
            check("R1", "energy_det_en", {31'b0, energy_det_en}, {31'b0, m_mode == 2});
            check("R3", "ready", {31'b0, ready}, {31'b0, m_ready()});
            check("R7", "phy_rst", {31'b0, phy_rst}, {31'b0, m_phy_left > 0});
            check("R5", "rdata", rdata, er);
            if (phy_rst) hi_cnt++;
        end
    end

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2;
        check(req, "read data", rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic probe(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        #2;
        check(req, what, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        probe("R9", "mode after reset", {30'b0, pwr_mode}, 32'h0);
        probe("R9", "ready after reset", {31'b0, ready}, 32'h1);
        probe("R9", "phy after reset", {31'b0, phy_rst}, 32'h0);

        // R6: locked before first read
        do_wr(CTRL, 32'h0000_1000);
        probe("R6", "write before read ignored", {30'b0, pwr_mode}, 32'h0);
        do_rd(OTHR, 32'h0, "R5");
        do_rd(CTRL, 32'h0000_0001, "R5");

        // R2: mode 11 ignored, bit 10 still acts
        hi_cnt = 0;
        do_wr(CTRL, 32'h0000_3400);
        probe("R2", "mode 11 ignored", {30'b0, pwr_mode}, 32'h0);
        probe("R2", "ready kept", {31'b0, ready}, 32'h1);
        probe("R7", "phy raised", {31'b0, phy_rst}, 32'h1);
        repeat (100) @(negedge clk);
        // R8: rewrites during hold
        do_wr(CTRL, 32'h0000_0400);
        repeat (50) @(negedge clk);
        do_wr(CTRL, 32'h0000_0000);
        while (phy_rst && hi_cnt < HOLD + 10) @(negedge clk);
        #2;
        check("R8", "hold length with rewrites", 32'(hi_cnt), 32'(HOLD));
        probe("R7", "phy released", {31'b0, phy_rst}, 32'h0);

        // R10: wake address in run mode
        do_wr(WAKE, 32'hFFFF_FFFF);
        probe("R10", "wake write in run", {30'b0, pwr_mode}, 32'h0);
        probe("R10", "ready in run", {31'b0, ready}, 32'h1);

        // R1/R3: wake-frame mode
        do_wr(CTRL, 32'h0000_1000);
        probe("R1", "wake-frame mode", {30'b0, pwr_mode}, 32'h1);
        probe("R1", "wake_frame_en", {31'b0, wake_frame_en}, 32'h1);
        probe("R3", "ready low in sleep", {31'b0, ready}, 32'h0);
        do_rd(CTRL, 32'h0000_1000, "R5");

        // R4: gated writes while not ready
        do_wr(CTRL, 32'h0000_0400);
        probe("R4", "phy untouched", {31'b0, phy_rst}, 32'h0);
        do_wr(CTRL, 32'h0000_2000);
        probe("R4", "mode untouched", {30'b0, pwr_mode}, 32'h1);
        do_wr(OTHR, 32'h0);
        probe("R4", "other addr no effect", {30'b0, pwr_mode}, 32'h1);

        // R3: wake and settle
        do_wr(WAKE, 32'h0);
        probe("R3", "mode back to normal", {30'b0, pwr_mode}, 32'h0);
        repeat (SETTLE - 1) @(negedge clk);
        probe("R3", "ready low at end of settle", {31'b0, ready}, 32'h0);
        @(negedge clk);
        probe("R3", "ready after settle", {31'b0, ready}, 32'h1);

        // R6: relocked after wake
        do_wr(CTRL, 32'h0000_2000);
        probe("R6", "write after wake ignored", {30'b0, pwr_mode}, 32'h0);
        do_rd(OTHR, 32'h0, "R5");
        do_wr(CTRL, 32'h0000_2000);
        probe("R1", "energy mode", {30'b0, pwr_mode}, 32'h2);
        probe("R1", "energy_det_en", {31'b0, energy_det_en}, 32'h1);
        do_rd(CTRL, 32'h0000_2000, "R5");

        // R6: wake works without a read, settle and return via normal write
        do_wr(WAKE, 32'h1234_5678);
        repeat (SETTLE + 2) @(negedge clk);
        probe("R3", "second wake ready", {31'b0, ready}, 32'h1);
        do_rd(CTRL, 32'h0000_0001, "R5");
        do_wr(CTRL, 32'h0000_0000);
        probe("R1", "normal write keeps normal", {30'b0, pwr_mode}, 32'h0);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule